// File: doc/BRIEF.md
# I2C Transmit/Receive Byte Queues with Trigger Levels

This block holds the bytes that pass between a register-mapped data port and an I2C byte engine. Software writes outgoing bytes into a transmit queue, and the engine drains that queue one byte at a time. The engine stores incoming bytes in a receive queue, and software reads them from the same data port. Each queue holds 16 bytes, and each one's fill level can be read at its own address.

Software programs two trigger thresholds. The receive threshold is a byte count. The transmit threshold is a two-bit code that selects how few bytes may remain before the queue asks for a refill. Three sticky status flags report these conditions and the end of transmission. Software clears each flag by writing 0 to its bit. Each flag has its own interrupt enable. While the receive-ready flag or the transmit-end flag is set, the block asks the engine to hold the clock line low.

Top module: `i2c_fifo_pair`

## Requirements
- R1: Each queue holds at most 16 bytes. The receive fill count reads at address 4 and the transmit fill count at address 5, in bits [4:0].
- R2: A write to address 0 appends a byte to the transmit queue. The write is dropped when that queue already holds 16 bytes.
- R3: A read of address 0 returns the oldest receive byte and removes it. When the receive queue is empty, the read returns 0 and changes nothing.
- R4: Address 1 is the control register. Writing bit0 = 1 empties the transmit queue and bit1 = 1 empties the receive queue. Both are one-shot actions that always read back as 0. Bits [7:4] and [3:2] are stored and read back.
- R5: Control bits [7:4] hold T-1, where T is the receive threshold. Status bit1 sets while the receive count is at least T.
- R6: Control bits [3:2] hold a code c that gives the transmit level 8>>c (8, 4, 2 or 1). Status bit0 sets while the transmit count is at or below that level.
- R7: Status bit2 sets when the engine reports a byte fully sent (eng_sent) while the transmit queue is empty. It does not set if bytes remain.
- R8: A write to address 2 clears each status bit written 0 and keeps each bit written 1. A flag whose condition still holds is set again.
- R9: Address 3 holds the interrupt enables in bits [2:0], matched to status bits [2:0]. irq is high while any enabled flag is set.
- R10: scl_hold is high exactly while status bit1 or status bit2 is set.
- R11: The engine sees the oldest transmit byte on eng_tx_data, with eng_tx_avail high when the queue is not empty, and removes it with eng_tx_pop. eng_rx_push stores eng_rx_data, and the push is dropped when the receive queue is full.
- R12: After reset both queues are empty, and the control register and the enables read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops the receive queue at address 0) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, from the current state |
| eng_tx_avail | output | 1 | Transmit queue not empty |
| eng_tx_data | output | 8 | Oldest transmit byte |
| eng_tx_pop | input | 1 | Engine takes the transmit byte |
| eng_rx_push | input | 1 | Engine delivers a received byte |
| eng_rx_data | input | 8 | Received byte |
| eng_sent | input | 1 | Engine finished sending a byte |
| scl_hold | output | 1 | Request to stretch the clock line |
| irq | output | 1 | Interrupt request |

## Verification
Queue contents and fill counts change at the clock edge that captures a write, a pop or a push, so they can be read just after that edge. Status flags are computed from the registered counts, so each flag follows its condition one edge later. For this reason the bench always writes the status register after a count change and then reads the flag, which shows the condition on the now-settled count. Threshold behaviour is swept over every transmit code against fill levels 0 to 16 and over every receive threshold against every fill level. Queue order, overflow drops and empty reads are checked at both boundaries.

// File: rtl/i2c_fifo_pkg.sv
package i2c_fifo_pkg;
    localparam int BYTE_W = 8;
    localparam int NFLAG  = 3;

    typedef enum logic [2:0] {
        A_DATA   = 3'd0,
        A_CTRL   = 3'd1,
        A_STAT   = 3'd2,
        A_IEN    = 3'd3,
        A_RXCNT  = 3'd4,
        A_TXCNT  = 3'd5
    } reg_addr_e;

    localparam int F_TXLOW = 0;
    localparam int F_RXRDY = 1;
    localparam int F_TEND  = 2;
endpackage

// File: rtl/byte_fifo.sv
module byte_fifo #(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = PTR_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             push,
    input  logic [DW-1:0]    push_data,
    input  logic             pop,
    output logic [DW-1:0]    head,
    output logic [CNT_W-1:0] count
);
    typedef struct packed {
        logic [DEPTH-1:0][DW-1:0] mem;
        logic [PTR_W-1:0]         wp;
        logic [PTR_W-1:0]         rp;
        logic [CNT_W-1:0]         cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic push_ok, pop_ok;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d    = st_q;
        push_ok = push && (st_q.cnt != CNT_W'(DEPTH));
        pop_ok  = pop && (st_q.cnt != '0);
        if (push_ok) begin
            st_d.mem[st_q.wp] = push_data;
            st_d.wp           = bump(st_q.wp);
        end
        if (pop_ok) begin
            st_d.rp = bump(st_q.rp);
        end
        st_d.cnt = st_q.cnt + CNT_W'(push_ok) - CNT_W'(pop_ok);
        if (clr) begin
            st_d.wp  = '0;
            st_d.rp  = '0;
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign head  = st_q.mem[st_q.rp];
    assign count = st_q.cnt;

    // R2
    full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && !clr && count == CNT_W'(DEPTH)) |=> count == CNT_W'(DEPTH));
    // R3
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && !clr && count == '0) |=> count == '0);
    // R4
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> count == '0);
    // R1
    bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));
endmodule

// File: rtl/fifo_flags.sv
module fifo_flags
    import i2c_fifo_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CNT_W  = $clog2(DEPTH) + 1,
    localparam int TRIG_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  rx_cnt,
    input  logic [CNT_W-1:0]  tx_cnt,
    input  logic [TRIG_W-1:0] rx_trig,
    input  logic [1:0]        tx_code,
    input  logic              sent,
    input  logic              wr_stat,
    input  logic [NFLAG-1:0]  keep,
    output logic [NFLAG-1:0]  flags
);
    logic [NFLAG-1:0] flg_d, flg_q, set_now;
    logic [CNT_W-1:0] rx_need, tx_level;

    always_comb begin
        rx_need  = CNT_W'(rx_trig) + 1'b1;
        tx_level = CNT_W'((DEPTH / 2) >> tx_code);
        set_now          = '0;
        set_now[F_TXLOW] = (tx_cnt <= tx_level);
        set_now[F_RXRDY] = (rx_cnt >= rx_need);
        set_now[F_TEND]  = sent && (tx_cnt == '0);
        flg_d = (flg_q & (wr_stat ? keep : '1)) | set_now;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flg_q <= '0;
        else        flg_q <= flg_d;
    end

    assign flags = flg_q;

    // R7
    tend_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[F_TEND]) |-> $past(sent));
    // R5
    rx_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_cnt >= CNT_W'(rx_trig) + 1'b1) |=> flags[F_RXRDY]);
    // R8
    rx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && !keep[F_RXRDY] && rx_cnt < CNT_W'(rx_trig) + 1'b1) |=> !flags[F_RXRDY]);
endmodule

// File: rtl/i2c_fifo_pair.sv
module i2c_fifo_pair
    import i2c_fifo_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [2:0]  reg_addr,
    input  logic [7:0]  reg_wdata,
    output logic [7:0]  reg_rdata,
    output logic        eng_tx_avail,
    output logic [7:0]  eng_tx_data,
    input  logic        eng_tx_pop,
    input  logic        eng_rx_push,
    input  logic [7:0]  eng_rx_data,
    input  logic        eng_sent,
    output logic        scl_hold,
    output logic        irq
);
    localparam int CNT_W  = $clog2(DEPTH) + 1;
    localparam int TRIG_W = $clog2(DEPTH);

    typedef struct packed {
        logic [TRIG_W-1:0] rx_trig;
        logic [1:0]        tx_code;
        logic [NFLAG-1:0]  ien;
    } cfg_st_t;

    cfg_st_t cfg_d, cfg_q;
    logic [CNT_W-1:0]  rx_cnt, tx_cnt;
    logic [BYTE_W-1:0] rx_head;
    logic [NFLAG-1:0]  flags;
    logic wr_data, wr_ctrl, wr_stat, wr_ien, rd_data;

    always_comb begin
        wr_data = reg_wr && (reg_addr == A_DATA);
        wr_ctrl = reg_wr && (reg_addr == A_CTRL);
        wr_stat = reg_wr && (reg_addr == A_STAT);
        wr_ien  = reg_wr && (reg_addr == A_IEN);
        rd_data = reg_rd && (reg_addr == A_DATA);
        cfg_d = cfg_q;
        if (wr_ctrl) begin
            cfg_d.rx_trig = reg_wdata[4 +: TRIG_W];
            cfg_d.tx_code = reg_wdata[3:2];
        end
        if (wr_ien) cfg_d.ien = reg_wdata[NFLAG-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    byte_fifo #(.DEPTH(DEPTH), .DW(BYTE_W)) u_tx (
        .clk(clk), .rst_n(rst_n),
        .clr(wr_ctrl && reg_wdata[0]),
        .push(wr_data), .push_data(reg_wdata),
        .pop(eng_tx_pop),
        .head(eng_tx_data), .count(tx_cnt)
    );

    byte_fifo #(.DEPTH(DEPTH), .DW(BYTE_W)) u_rx (
        .clk(clk), .rst_n(rst_n),
        .clr(wr_ctrl && reg_wdata[1]),
        .push(eng_rx_push), .push_data(eng_rx_data),
        .pop(rd_data),
        .head(rx_head), .count(rx_cnt)
    );

    fifo_flags #(.DEPTH(DEPTH)) u_flags (
        .clk(clk), .rst_n(rst_n),
        .rx_cnt(rx_cnt), .tx_cnt(tx_cnt),
        .rx_trig(cfg_q.rx_trig), .tx_code(cfg_q.tx_code),
        .sent(eng_sent),
        .wr_stat(wr_stat), .keep(reg_wdata[NFLAG-1:0]),
        .flags(flags)
    );

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_DATA:  reg_rdata = (rx_cnt == '0) ? '0 : rx_head;
            A_CTRL:  reg_rdata = {4'(cfg_q.rx_trig), cfg_q.tx_code, 2'b00};
            A_STAT:  reg_rdata = 8'(flags);
            A_IEN:   reg_rdata = 8'(cfg_q.ien);
            A_RXCNT: reg_rdata = 8'(rx_cnt);
            A_TXCNT: reg_rdata = 8'(tx_cnt);
            default: reg_rdata = '0;
        endcase
    end

    assign eng_tx_avail = (tx_cnt != '0);
    assign scl_hold     = flags[F_RXRDY] | flags[F_TEND];
    assign irq          = |(flags & cfg_q.ien);

    // R9
    irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q.ien == '0) |-> !irq);
    // R10
    hold_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_hold) |-> ($past(eng_sent) || rx_cnt != '0));
endmodule

// File: tb/tb_i2c_fifo_pair.sv
module tb_i2c_fifo_pair;
    logic clk = 0, rst_n = 0;
    logic reg_wr = 0, reg_rd = 0;
    logic [2:0] reg_addr = 0;
    logic [7:0] reg_wdata = 0, reg_rdata;
    logic eng_tx_avail, eng_tx_pop = 0, eng_rx_push = 0, eng_sent = 0;
    logic [7:0] eng_tx_data, eng_rx_data = 0;
    logic scl_hold, irq;
    int checks = 0, fails = 0;
    bit done = 0;
    logic [7:0] v;

    always #2.5 clk = ~clk;

    i2c_fifo_pair dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .eng_tx_avail(eng_tx_avail), .eng_tx_data(eng_tx_data),
        .eng_tx_pop(eng_tx_pop), .eng_rx_push(eng_rx_push),
        .eng_rx_data(eng_rx_data), .eng_sent(eng_sent),
        .scl_hold(scl_hold), .irq(irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic peek(input logic [2:0] a, output logic [7:0] d);
        reg_addr = a; #1; d = reg_rdata;
    endtask

    task automatic pop(output logic [7:0] d);
        reg_addr = 0; #1; d = reg_rdata; reg_rd = 1;
        @(negedge clk);
        reg_rd = 0;
    endtask

    task automatic rx_push(input logic [7:0] d);
        eng_rx_data = d; eng_rx_push = 1;
        @(negedge clk);
        eng_rx_push = 0;
    endtask

    task automatic tx_take(output logic [7:0] d);
        #1; d = eng_tx_data; eng_tx_pop = 1;
        @(negedge clk);
        eng_tx_pop = 0;
    endtask

    task automatic sent_pulse();
        eng_sent = 1;
        @(negedge clk);
        eng_sent = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R12 reset state
        peek(1, v); chk("R12 ctrl", v, 0);
        peek(3, v); chk("R12 ien", v, 0);
        peek(4, v); chk("R12 rxcnt", v, 0);
        peek(5, v); chk("R12 txcnt", v, 0);
        chk("R12 irq", irq, 0);
        chk("R12 avail", eng_tx_avail, 0);

        // R6 sweep of transmit codes against fill levels
        for (int c = 0; c < 4; c++) begin
            wr(1, 8'((c << 2) | 1));
            for (int k = 0; k <= 16; k++) begin
                if (k > 0) wr(0, 8'(k));
                wr(2, 0);
                peek(5, v); chk("R1 txcnt", v, k);
                peek(2, v); chk("R6 txlow", v[0], (k <= (8 >> c)) ? 1 : 0);
            end
        end
        // R2 overflow drop
        wr(0, 8'hEE);
        peek(5, v); chk("R2 full drop", v, 16);
        // R11 engine drain in order
        for (int i = 1; i <= 16; i++) begin
            chk("R11 avail", eng_tx_avail, 1);
            tx_take(v); chk("R11 txdata", v, i);
        end
        chk("R11 empty", eng_tx_avail, 0);

        // R5 sweep of receive thresholds against fill levels
        for (int n = 1; n <= 16; n++) begin
            wr(1, 8'(((n - 1) << 4) | 2));
            peek(4, v); chk("R4 rx reset", v, 0);
            for (int k = 1; k <= 16; k++) begin
                rx_push(8'(k + n));
                wr(2, 0);
                peek(2, v); chk("R5 rxrdy", v[1], (k >= n) ? 1 : 0);
                if (k >= n) chk("R10 hold", scl_hold, 1);
            end
        end
        rx_push(8'h99);
        peek(4, v); chk("R11 rx full drop", v, 16);
        for (int k = 1; k <= 16; k++) begin
            pop(v); chk("R3 rx order", v, 8'(k + 16));
        end
        pop(v); chk("R3 empty read", v, 0);
        peek(4, v); chk("R3 empty cnt", v, 0);
        wr(2, 0);
        peek(2, v); chk("R8 rx cleared", v[1], 0);
        chk("R10 hold off", scl_hold, 0);

        // R7 transmit end
        sent_pulse();
        peek(2, v); chk("R7 tend", v[2], 1);
        chk("R10 hold tend", scl_hold, 1);
        wr(2, 0);
        peek(2, v); chk("R8 tend clear", v[2], 0);
        wr(0, 8'h5A);
        sent_pulse();
        peek(2, v); chk("R7 no tend", v[2], 0);
        tx_take(v); chk("R11 byte", v, 8'h5A);
        sent_pulse();
        wr(2, 8'h04);
        peek(2, v); chk("R8 keep", v, 8'h05);

        // R9 interrupt masking
        wr(3, 0); chk("R9 irq none", irq, 0);
        wr(3, 1); chk("R9 irq txlow", irq, 1);
        wr(3, 2); chk("R9 irq rx masked", irq, 0);
        wr(3, 4); chk("R9 irq tend", irq, 1);
        peek(3, v); chk("R9 ien readback", v, 4);

        // R4 reset bits are pulses
        wr(0, 8'h11);
        rx_push(8'h22);
        wr(1, 8'hA7);
        peek(1, v); chk("R4 ctrl readback", v, 8'hA4);
        peek(5, v); chk("R4 tx reset", v, 0);
        peek(4, v); chk("R4 rx reset", v, 0);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule